// File: doc/BRIEF.md
# Up/down trim counter controller

This block is the digital control for an 8-bit trimmer DAC code, driven through three asynchronous wires: an active-low select, a falling-edge step strobe and a direction level. While selected, each falling edge of the step line moves the working code one position up or down, and the code stops at either end of its range. The code drives the DAC directly.

When select is released, the level of the step line at that moment decides whether the adjustment is kept. If the step line is high, the block issues a one-cycle store request that carries the current code to the nonvolatile store. It then raises busy for a write window derived from the clock frequency and the write time. If the step line is low, nothing is written, so the next power-up recalls the previous value. During reset the working register loads the value presented by the nonvolatile store.

All three control inputs pass through two-flop synchronizers before any edge is detected. While busy is high, step edges and select releases have no effect.

Top module: `trim_ctrl_top`

## Requirements
- R1: While `rst` is high, `code` takes the value on `nv_data`. After reset `busy` and `store_req` are 0.
- R2: A falling edge on `step_n` while `sel_n` is low and `dir_up` is 1 raises `code` by one.
- R3: A falling edge on `step_n` while `sel_n` is low and `dir_up` is 0 lowers `code` by one.
- R4: `code` saturates. A step up at 0xFF leaves 0xFF, and a step down at 0x00 leaves 0x00.
- R5: While `sel_n` is high, step edges leave `code` unchanged.
- R6: A rising edge of `sel_n` while `step_n` is high gives a single-cycle `store_req` with `store_data` equal to `code`.
- R7: A rising edge of `sel_n` while `step_n` is low gives no `store_req`, so a following reset recalls the previously stored code.
- R8: `busy` is high for exactly WRITE_CYC clock cycles, starting in the cycle of `store_req`. WRITE_CYC = CLK_HZ/1e6 × WRITE_US.
- R9: While `busy` is high, step edges leave `code` unchanged and a select release gives no `store_req`.
- R10: A rising edge on `step_n` does not change `code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the code from `nv_data` |
| sel_n | input | 1 | Active-low select, asynchronous |
| step_n | input | 1 | Step strobe; acts on its falling edge, asynchronous |
| dir_up | input | 1 | Direction: 1 counts up, 0 counts down |
| nv_data | input | CODE_W | Value held in the nonvolatile store |
| code | output | CODE_W | Working code to the DAC |
| store_req | output | 1 | One-cycle request to write `store_data` |
| store_data | output | CODE_W | Code to be written |
| busy | output | 1 | Write window in progress |

## Verification
The step strobe and the select release can be seen in the same cycle. The bench provokes this by pulling `step_n` low and raising `sel_n` in the same time step, so both cross the synchronizers together. The expected result is that no step happens, because the block is already deselected, and no store happens, because the step level is low. The bench judges this by comparing `code` with its earlier value and by confirming that the memory stub is unchanged across a reset. A second overlap, step edges and a select release arriving inside the busy window, is driven directly after a store and judged by the request count and by the code holding steady.

// File: rtl/trim_pkg.sv
package trim_pkg;
  // clock cycles needed to cover a write window of us_val microseconds
  function automatic int unsigned write_cycles(input longint unsigned hz,
                                               input longint unsigned us_val);
    longint unsigned c;
    c = (hz / 64'd1000000) * us_val;
    if (c == 0) c = 1;
    return int'(c);
  endfunction
endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/trim_step.sv
module trim_step #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] load_val,
  input  logic              en,
  input  logic              up,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] BOT = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      code <= load_val;
    end else if (en) begin
      if (up && code != TOP)       code <= code + 1'b1;
      else if (!up && code != BOT) code <= code - 1'b1;
    end
  end

  // R2 / R4: stepping up moves by one below the top and holds at the top
  a_r2_step_up: assert property (@(posedge clk) disable iff (rst)
    (en && up && code != TOP) |=> (code == $past(code) + 1'b1));
  a_r4_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (en && up && code == TOP) |=> (code == TOP));
  a_r4_no_wrap_dn: assert property (@(posedge clk) disable iff (rst)
    (en && !up && code == BOT) |=> (code == BOT));
endmodule

// File: rtl/trim_wtimer.sv
module trim_wtimer #(
  parameter int unsigned CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LOAD = CW'(CYC - 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/trim_ctrl_top.sv
module trim_ctrl_top #(
  parameter int          CODE_W   = 8,
  parameter longint unsigned CLK_HZ   = 50000000,
  parameter longint unsigned WRITE_US = 5000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              step_n,
  input  logic              dir_up,
  input  logic [CODE_W-1:0] nv_data,
  output logic [CODE_W-1:0] code,
  output logic              store_req,
  output logic [CODE_W-1:0] store_data,
  output logic              busy
);
  localparam int unsigned WRITE_CYC = trim_pkg::write_cycles(CLK_HZ, WRITE_US);

  logic [2:0] raw_in, sync_in;
  logic       sel_s, step_s, dir_s;
  logic       sel_q, step_q;
  logic       step_fall, sel_rise, step_ok, store_go;

  assign raw_in = {sel_n, step_n, dir_up};

  trim_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(sync_in)
  );
  assign {sel_s, step_s, dir_s} = sync_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b1;
      step_q <= 1'b1;
    end else begin
      sel_q  <= sel_s;
      step_q <= step_s;
    end
  end

  assign step_fall = step_q && !step_s;
  assign sel_rise  = !sel_q && sel_s;
  assign step_ok   = step_fall && !sel_s && !busy;
  assign store_go  = sel_rise && step_s && !busy;

  trim_step #(.CODE_W(CODE_W)) u_step (
    .clk(clk), .rst(rst), .load_val(nv_data),
    .en(step_ok), .up(dir_s), .code(code)
  );

  trim_wtimer #(.CYC(WRITE_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(store_go), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      store_req  <= 1'b0;
      store_data <= '0;
    end else begin
      store_req <= store_go;
      if (store_go) store_data <= code;
    end
  end

  // R11-style pulse width folded into R6: a request lasts one cycle
  a_r6_req_pulse: assert property (@(posedge clk) disable iff (rst)
    store_req |=> !store_req);
  a_r6_req_data: assert property (@(posedge clk) disable iff (rst)
    store_req |-> (store_data == code));
  a_r8_req_busy: assert property (@(posedge clk) disable iff (rst)
    store_req |-> busy);
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(code));
  a_r9_busy_no_req: assert property (@(posedge clk) disable iff (rst)
    busy |=> !store_req);
  a_r5_standby_hold: assert property (@(posedge clk) disable iff (rst)
    sel_s |=> $stable(code));
endmodule

// File: tb/sim_trim_ctrl_top.sv
module sim_trim_ctrl_top;
  localparam time PERIOD = 10ns;
  localparam int  CW     = 8;
  localparam int  WCYC   = 40; // 4 MHz x 10 us

  logic clk = 0, rst = 1, sel_n = 1, step_n = 1, dir_up = 0;
  logic [CW-1:0] code, store_data, mem;
  logic store_req, busy;
  logic preset_en = 0;
  logic [CW-1:0] preset_val = '0;
  int n_chk = 0, n_bad = 0, n_req = 0, n_busy = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  trim_ctrl_top #(.CODE_W(CW), .CLK_HZ(4000000), .WRITE_US(10)) u0 (
    .clk(clk), .rst(rst), .sel_n(sel_n), .step_n(step_n), .dir_up(dir_up),
    .nv_data(mem), .code(code), .store_req(store_req),
    .store_data(store_data), .busy(busy)
  );

  // nonvolatile stub: survives reset
  always @(posedge clk) begin
    if (preset_en) mem <= preset_val;
    else if (store_req) begin
      mem   <= store_data;
      n_req <= n_req + 1;
    end
  end
  always @(negedge clk) if (busy) n_busy <= n_busy + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preset(input logic [CW-1:0] v);
    @(negedge clk); preset_val = v; preset_en = 1;
    @(negedge clk); preset_en = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1;
    wait_n(3);
    check("R1 code during reset", code, mem);
    rst = 0;
    wait_n(1);
    check("R1 busy after reset", busy, 0);
    check("R1 req after reset", store_req, 0);
  endtask

  // one full step pulse; checks code after the fall and after the rise
  task automatic pulse(input logic d, input int exp, input string req);
    dir_up = d;
    wait_n(3);
    step_n = 0;
    wait_n(5);
    check(req, code, exp);
    step_n = 1;
    wait_n(5);
    check("R10 rising edge inert", code, exp);
  endtask

  // columns: dir, expected code; start value 0xFD
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'hFE}, {1'b1, 8'hFF}, {1'b1, 8'hFF},
    {1'b0, 8'hFE}, {1'b0, 8'hFD}, {1'b1, 8'hFE}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    int r0;
    logic [CW-1:0] hold;
    preset(8'hFD);
    do_reset();
    check("R1 recall", code, 8'hFD);

    sel_n = 0; wait_n(4);
    for (int i = 0; i < 6; i++)
      pulse(VEC[i][8], VEC[i][7:0], VEC[i][8] ? "R2/R4 up" : "R3 down");

    // R6 + R8: release with step high
    r0 = n_req; n_busy = 0;
    sel_n = 1;
    wait_n(6);
    check("R6 one request", n_req - r0, 1);
    check("R6 stored value", mem, 8'hFE);
    // R9: activity inside the busy window
    sel_n = 0; wait_n(3);
    dir_up = 1; step_n = 0; wait_n(5);
    check("R9 step ignored while busy", code, 8'hFE);
    step_n = 1; wait_n(4);
    sel_n = 1; wait_n(4);
    check("R9 still busy", busy, 1);
    wait_n(WCYC + 10);
    check("R9 no second request", n_req - r0, 1);
    check("R8 busy length", n_busy, WCYC);

    // R5: standby ignores steps
    pulse(1'b1, 8'hFE, "R5 standby holds");

    // R7: release with step low, same time step as the fall
    sel_n = 0; wait_n(4);
    pulse(1'b1, 8'hFF, "R2 up before abort");
    hold = code;
    r0 = n_req;
    step_n = 0; sel_n = 1;
    wait_n(6);
    check("R7 no step on simultaneous release", code, hold);
    check("R7 no request", n_req - r0, 0);
    step_n = 1; wait_n(4);
    do_reset();
    check("R7 old code recalled", code, 8'hFE);

    // R4 bottom
    preset(8'h01);
    do_reset();
    check("R1 recall low", code, 8'h01);
    sel_n = 0; wait_n(4);
    pulse(1'b0, 8'h00, "R3 down");
    pulse(1'b0, 8'h00, "R4 floor");
    pulse(1'b1, 8'h01, "R2 up from floor");
    sel_n = 1; wait_n(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule